// File: doc/BRIEF.md
# Mixed-Sign Radix-4 Multiplier Core

This block multiplies two 16-bit operands held in on-block registers and presents the 32-bit product. Each operand comes with its own signedness bit, which is captured along with the operand. Both operands can therefore be unsigned, both two's complement, or one of each. The registered Y operand is recoded with radix-4 (modified Booth) digits. The block builds nine partial products, reduces them through a carry-save chain, and resolves the result in one final carry-propagate adder.

A rounding request and a format selector are captured on every edge that loads either operand. When rounding is requested, a single positive one is folded into the carry-save array as an extra row. It lands at bit 15 when the format selector is high and at bit 14 when it is low. The product is a combinational function of the registers, so it changes right after the clock edge that loads new operands. No output register is present.

Top module: `booth_mul16`

## Requirements
- R1: With both sign bits captured low, `prod_o` equals the unsigned product of the registered operands (e.g. 0xFFFF × 0xFFFF = 0xFFFE0001).
- R2: With both sign bits captured high, `prod_o` equals the 32-bit two's complement product (e.g. 0x8000 × 0x8000 = 0x40000000, 0xFFFF × 0x7FFF = 0xFFFF8001).
- R3: The two sign bits act independently, so a mixed product is correct: X signed and Y unsigned, or X unsigned and Y signed (e.g. signed 0xFFFF × unsigned 0xFFFF = 0xFFFF0001).
- R4: On a rising edge, the X operand and its sign bit load only when `x_load_i` is 1, and the Y operand and its sign bit load only when `y_load_i` is 1. A register that is not loaded keeps its value.
- R5: The round request and the format selector load on a rising edge when either load enable is 1, and hold when both are 0.
- R6: With the captured round set and the captured format selector at 1, `prod_o` is (product + 0x8000) mod 2^32.
- R7: With the captured round set and the captured format selector at 0, `prod_o` is (product + 0x4000) mod 2^32.
- R8: Rounding always adds a positive constant whatever the sign of the product, and it wraps modulo 2^32 (signed −1 × unsigned 1 with round at bit 15 gives 0x00007FFF). With round clear, nothing is added.
- R9: While `rst_ni` is low, every register is cleared and `prod_o` is 0.
- R10: `prod_o` reflects the values loaded at a rising edge before the next rising edge, with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 16 | X operand (multiplicand) |
| y_i | input | 16 | Y operand (recoded multiplier) |
| x_signed_i | input | 1 | X is two's complement when 1, unsigned when 0 |
| y_signed_i | input | 1 | Y is two's complement when 1, unsigned when 0 |
| x_load_i | input | 1 | Load enable for the X operand and its sign bit |
| y_load_i | input | 1 | Load enable for the Y operand and its sign bit |
| round_i | input | 1 | Rounding request |
| fmt_full_i | input | 1 | Round position select: 1 = bit 15, 0 = bit 14 |
| prod_o | output | 32 | Product of the registered operands plus the rounding constant |

## Verification
The assertions check three things on every cycle. Each operand register, and the round and format pair, holds its value when its enable is low. Each Booth digit selects at most one multiple. A zero X operand gives a zero product, or exactly the rounding constant when round is set. Whether the full product is right for every mix of sign modes, the exact rounding offsets, and the wrap of a rounded negative product can only be shown by the bench. It runs corner operands in all four mode pairs and a long random sequence with random enables against a behavioural reference.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;

  // radix-4 digit from the bit triplet {y[2i+1], y[2i], y[2i-1]}
  function automatic booth_digit_t booth_recode(input logic [2:0] t);
    booth_digit_t d;
    d.one = t[1] ^ t[0];
    d.two = (t == 3'b011) || (t == 3'b100);
    d.neg = t[2] & ~(t[1] & t[0]);
    return d;
  endfunction

endpackage

// File: rtl/booth_in_regs.sv
module booth_in_regs #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             x_signed_i,
  input  logic             y_signed_i,
  input  logic             x_load_i,
  input  logic             y_load_i,
  input  logic             round_i,
  input  logic             fmt_full_i,
  output logic [WIDTH-1:0] x_q_o,
  output logic [WIDTH-1:0] y_q_o,
  output logic             x_signed_q_o,
  output logic             y_signed_q_o,
  output logic             round_q_o,
  output logic             fmt_full_q_o
);

  logic any_load;
  assign any_load = x_load_i | y_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q_o        <= '0;
      x_signed_q_o <= 1'b0;
    end else if (x_load_i) begin
      x_q_o        <= x_i;
      x_signed_q_o <= x_signed_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q_o        <= '0;
      y_signed_q_o <= 1'b0;
    end else if (y_load_i) begin
      y_q_o        <= y_i;
      y_signed_q_o <= y_signed_i;
    end
  end

  // round position follows the same edge as the operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      round_q_o    <= 1'b0;
      fmt_full_q_o <= 1'b0;
    end else if (any_load) begin
      round_q_o    <= round_i;
      fmt_full_q_o <= fmt_full_i;
    end
  end

  a_r4_x_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_load_i |=> ($stable(x_q_o) && $stable(x_signed_q_o)));

  a_r4_y_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_load_i |=> ($stable(y_q_o) && $stable(y_signed_q_o)));

  a_r5_round_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_load_i && !y_load_i) |=> ($stable(round_q_o) && $stable(fmt_full_q_o)));

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mul_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int EXT_W  = WIDTH + 1,
  parameter int NUM_PP = (EXT_W + 1) / 2,
  parameter int PROD_W = 2 * WIDTH
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [EXT_W-1:0]              x_ext_i,
  input  logic [EXT_W-1:0]              y_ext_i,
  output logic [NUM_PP-1:0][PROD_W-1:0] rows_o
);

  localparam int PAD_W = 2 * NUM_PP + 1;
  localparam int PP_W  = EXT_W + 1;

  logic [PAD_W-1:0] y_pad;
  assign y_pad = {{(PAD_W-EXT_W-1){y_ext_i[EXT_W-1]}}, y_ext_i, 1'b0};

  for (genvar i = 0; i < NUM_PP; i++) begin : g_pp
    booth_digit_t    dig;
    logic [PP_W-1:0] mag;
    logic [PP_W-1:0] pp;

    assign dig = booth_recode(y_pad[2*i+2 -: 3]);

    always_comb begin
      if (dig.two)      mag = {x_ext_i, 1'b0};
      else if (dig.one) mag = {x_ext_i[EXT_W-1], x_ext_i};
      else              mag = '0;
      pp = dig.neg ? (~mag + 1'b1) : mag;
    end

    assign rows_o[i] = {{(PROD_W-PP_W){pp[PP_W-1]}}, pp} << (2 * i);

    a_r1_digit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({dig.one, dig.two}));
  end

endmodule

// File: rtl/booth_csa_sum.sv
module booth_csa_sum #(
  parameter int NUM_ROWS = 10,
  parameter int PROD_W   = 32
) (
  input  logic [NUM_ROWS-1:0][PROD_W-1:0] rows_i,
  output logic [PROD_W-1:0]               sum_o
);

  logic [PROD_W-1:0] s_vec;
  logic [PROD_W-1:0] c_vec;

  // 3:2 compressor chain, one row absorbed per stage
  always_comb begin
    logic [PROD_W-1:0] ns;
    logic [PROD_W-1:0] nc;
    s_vec = rows_i[0];
    c_vec = rows_i[1];
    for (int i = 2; i < NUM_ROWS; i++) begin
      ns    = s_vec ^ c_vec ^ rows_i[i];
      nc    = ((s_vec & c_vec) | (s_vec & rows_i[i]) | (c_vec & rows_i[i])) << 1;
      s_vec = ns;
      c_vec = nc;
    end
  end

  assign sum_o = s_vec + c_vec;

endmodule

// File: rtl/booth_mul16.sv
module booth_mul16 #(
  parameter int WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  input  logic               x_signed_i,
  input  logic               y_signed_i,
  input  logic               x_load_i,
  input  logic               y_load_i,
  input  logic               round_i,
  input  logic               fmt_full_i,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int EXT_W    = WIDTH + 1;
  localparam int NUM_PP   = (EXT_W + 1) / 2;
  localparam int PROD_W   = 2 * WIDTH;
  localparam int NUM_ROWS = NUM_PP + 1;
  localparam logic [PROD_W-1:0] RND_HI = PROD_W'(1) << (WIDTH - 1);
  localparam logic [PROD_W-1:0] RND_LO = PROD_W'(1) << (WIDTH - 2);

  logic [WIDTH-1:0] x_q, y_q;
  logic             x_sg_q, y_sg_q, rnd_q, fmt_q;

  booth_in_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .x_i          (x_i),
    .y_i          (y_i),
    .x_signed_i   (x_signed_i),
    .y_signed_i   (y_signed_i),
    .x_load_i     (x_load_i),
    .y_load_i     (y_load_i),
    .round_i      (round_i),
    .fmt_full_i   (fmt_full_i),
    .x_q_o        (x_q),
    .y_q_o        (y_q),
    .x_signed_q_o (x_sg_q),
    .y_signed_q_o (y_sg_q),
    .round_q_o    (rnd_q),
    .fmt_full_q_o (fmt_q)
  );

  // one extra bit: zero for unsigned, sign copy for two's complement
  logic [EXT_W-1:0] x_ext, y_ext;
  assign x_ext = {x_sg_q & x_q[WIDTH-1], x_q};
  assign y_ext = {y_sg_q & y_q[WIDTH-1], y_q};

  logic [NUM_PP-1:0][PROD_W-1:0]   pp_rows;
  logic [NUM_ROWS-1:0][PROD_W-1:0] all_rows;
  logic [PROD_W-1:0]               rnd_row;

  booth_pp_gen #(
    .WIDTH (WIDTH),
    .EXT_W (EXT_W),
    .NUM_PP(NUM_PP),
    .PROD_W(PROD_W)
  ) u_ppgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_ext_i(x_ext),
    .y_ext_i(y_ext),
    .rows_o (pp_rows)
  );

  assign rnd_row = rnd_q ? (fmt_q ? RND_HI : RND_LO) : '0;

  always_comb begin
    for (int i = 0; i < NUM_PP; i++) all_rows[i] = pp_rows[i];
    all_rows[NUM_PP] = rnd_row;
  end

  booth_csa_sum #(
    .NUM_ROWS(NUM_ROWS),
    .PROD_W  (PROD_W)
  ) u_sum (
    .rows_i(all_rows),
    .sum_o (prod_o)
  );

  a_r1_zero_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q == '0 && !rnd_q) |-> (prod_o == '0));

  a_r6_round_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q == '0 && rnd_q && fmt_q) |-> (prod_o == RND_HI));

  a_r7_round_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q == '0 && rnd_q && !fmt_q) |-> (prod_o == RND_LO));

endmodule

// File: tb/booth_mul16_bench.sv
module booth_mul16_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] x_i = '0, y_i = '0;
  logic        x_signed_i = 0, y_signed_i = 0, x_load_i = 0, y_load_i = 0;
  logic        round_i = 0, fmt_full_i = 0;
  logic [31:0] prod_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] m_x = '0, m_y = '0;
  logic        m_xs = 0, m_ys = 0, m_rnd = 0, m_fmt = 0;

  always #2 clk_i = ~clk_i;

  booth_mul16 u_booth_mul16 (
    .clk_i, .rst_ni, .x_i, .y_i, .x_signed_i, .y_signed_i,
    .x_load_i, .y_load_i, .round_i, .fmt_full_i, .prod_o
  );

  function automatic logic [31:0] ref_prod();
    longint a, b, p;
    a = m_xs ? longint'($signed(m_x)) : longint'(m_x);
    b = m_ys ? longint'($signed(m_y)) : longint'(m_y);
    p = a * b;
    if (m_rnd) p = p + (m_fmt ? 64'sd32768 : 64'sd16384);
    return p[31:0];
  endfunction

  task automatic check(input string tag);
    logic [31:0] exp_v;
    exp_v = ref_prod();
    checks++;
    if (prod_o !== exp_v) begin
      failures++;
      $display("FAIL %s: prod_o=%h expected=%h", tag, prod_o, exp_v);
    end
  endtask

  // drive at negedge, clock once, model the edge, compare at next negedge
  task automatic step(input logic [15:0] x, input logic [15:0] y,
                      input logic xs, input logic ys, input logic xl, input logic yl,
                      input logic rnd, input logic fmt, input string tag);
    x_i = x; y_i = y; x_signed_i = xs; y_signed_i = ys;
    x_load_i = xl; y_load_i = yl; round_i = rnd; fmt_full_i = fmt;
    @(posedge clk_i);
    if (xl) begin m_x = x; m_xs = xs; end
    if (yl) begin m_y = y; m_ys = ys; end
    if (xl || yl) begin m_rnd = rnd; m_fmt = fmt; end
    @(negedge clk_i);
    check(tag);
  endtask

  function automatic string mode_tag(input logic xs, input logic ys);
    if (!xs && !ys) return "R1";
    if (xs && ys)   return "R2";
    return "R3";
  endfunction

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [4];
    corners[0] = 16'h0000; corners[1] = 16'h7FFF;
    corners[2] = 16'h8000; corners[3] = 16'hFFFF;

    // R9: reset state
    repeat (3) @(negedge clk_i);
    check("R9");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9");

    // R1 R2 R3: corners across all mode pairs, no rounding
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          step(corners[i], corners[j], m[1], m[0], 1, 1, 0, 1, mode_tag(m[1], m[0]));

    // R6 R7: rounding at both positions on corners
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          step(corners[i], corners[j], 1, 0, 1, 1, 1, f[0], f[0] ? "R6" : "R7");

    // R8: positive-only round with wrap: -1 * 1 + 0x8000 = 0x00007FFF
    step(16'hFFFF, 16'h0001, 1, 0, 1, 1, 1, 1, "R8");
    if (prod_o !== 32'h00007FFF) begin
      failures++;
      $display("FAIL R8: prod_o=%h expected=%h", prod_o, 32'h00007FFF);
    end
    checks++;
    step(16'h1234, 16'h5678, 0, 0, 1, 1, 0, 0, "R8");

    // R10: new product visible in the cycle after the loading edge
    step(16'h0003, 16'h0005, 0, 0, 1, 1, 0, 1, "R10");
    if (prod_o !== 32'd15) begin
      failures++;
      $display("FAIL R10: prod_o=%h expected=%h", prod_o, 32'd15);
    end
    checks++;

    // R4: X held while only Y loads, then Y held while only X loads
    step(16'hAAAA, 16'h0007, 1, 1, 0, 1, 0, 1, "R4");
    step(16'h0009, 16'h5555, 0, 0, 1, 0, 0, 1, "R4");
    // R5: no load, round/format and operands held
    step(16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 1, 0, "R5");
    step(16'h0100, 16'h0100, 0, 0, 0, 1, 1, 1, "R5");
    step(16'h0001, 16'h0001, 0, 0, 0, 0, 0, 0, "R5");
    step(16'h0002, 16'h0002, 0, 0, 1, 0, 1, 0, "R5");

    // random sequence with random enables
    for (int k = 0; k < 600; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(16'($urandom), 16'($urandom), r[0], r[1], $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, r[2], r[3], mode_tag(r[0], r[1]));
    end

    // R9: asynchronous reset clears a loaded product
    rst_ni = 1'b0;
    m_x = '0; m_y = '0; m_xs = 0; m_ys = 0; m_rnd = 0; m_fmt = 0;
    #1;
    check("R9");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule